// File: doc/BRIEF.md
# Square Channel Period Sweep Unit

This block owns the automatic pitch glide of one square-wave sound channel. It keeps a shadow copy of the channel's 11-bit period. At a programmable pace, counted in sweep frame ticks, it schedules a calculation that adds a right-shifted copy of the period to itself, or subtracts it. When the calculation finishes, it either writes the new period back to the channel or, if the sum passes the 11-bit range, turns the channel off.

The calculation does not happen at once. A countdown, clocked by a fast calculation tick at twice the base rate, delays it. The load value of that countdown depends on the shift amount and on the phase of the calculation tick. A trigger also starts an overflow-check calculation with no write-back whenever the shift is nonzero, and a channel that was silent before the trigger waits two counts longer. A control write that clears the subtract bit can silence the channel at once when the last calculation was a subtraction.

Top module: `sq_sweep_unit`

## Requirements
- R1: The 7-bit control value holds the sweep pace in bits 6:4, the subtract flag in bit 3 and the shift amount in bits 2:0. A write with `cfg_we` takes effect at the next clock edge.
- R2: While the channel is active and the pace is nonzero, a calculation is scheduled on every pace-th `frame_tick`. The first one comes on the pace-th tick after a trigger. A pace of zero never schedules one.
- R3: A calculation scheduled by a frame tick completes on the L-th advancing `calc_tick` after scheduling. L = 2*shift + 5 - phase, where phase is the parity of the number of `calc_tick` pulses since reset.
- R4: The countdown advances only when the current shift is nonzero, or the shift was zero when the calculation was scheduled, or the remaining count is 3 or less. Otherwise it holds its value.
- R5: A calculation adds shadow>>shift to the shadow period, or subtracts it when the subtract flag is set. An addition above 0x7FF clears `ch_active` and produces no load.
- R6: A frame-scheduled calculation with a nonzero shift and no overflow, on an active channel, puts the result on `period_out` with a one-cycle `period_load` pulse. The result also becomes the new shadow period.
- R7: A control write whose bit 3 is 0 clears `ch_active` at once when shadow + last completed addend + old subtract flag exceeds 0x7FF. A completed subtraction stores the 11-bit inverted addend. A write that keeps bit 3 at 1 never does this.
- R8: A trigger sets `ch_active`, loads the shadow period from `trig_period`, clears the completed addend and reloads the pace counter. With a nonzero shift it schedules an overflow check of delay L, plus 2 when the channel was inactive. That check never loads a period.
- R9: After reset `ch_active`, `period_load` and `period_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control value: pace, subtract flag, shift |
| trig | input | 1 | Channel trigger strobe |
| trig_period | input | 11 | Channel period at trigger time |
| frame_tick | input | 1 | Sweep frame tick |
| calc_tick | input | 1 | Calculation tick at twice the base rate |
| period_out | output | 11 | Last period written back |
| period_load | output | 1 | One-cycle strobe when period_out is updated |
| ch_active | output | 1 | Channel-active flag |

## Verification
The bench measures the calculation delay for every shift value from 1 to 7 at both phases. A design with an off-by-one in the delay, or with the phase term inverted, would load one tick early or late.

It also checks the trigger-time overflow check, both from a silent channel and from an active one. A design that dropped the cold-start extra counts would kill the channel early, and one that wrote back from this check would change `period_out`.

A separate sequence subtracts first and then clears the subtract flag. A design without the stored inverted addend would leave the channel alive.

A further case holds the countdown paused by writing a zero shift mid-count. A design that kept counting would load during the pause.

// File: rtl/sq_sweep_pkg.sv
`timescale 1ns/1ps
package sq_sweep_pkg;
  localparam int SHIFT_W = 3;
  localparam int PACE_W  = 3;
  // enough for 2*7 + 5 + 2 = 21
  localparam int CDW     = 5;
  localparam int MAX_DLY = 2 * ((1 << SHIFT_W) - 1) + 5 + 2;
  localparam int HOLD_LIM = 3;

  typedef struct packed {
    logic [PACE_W-1:0]  pace;
    logic               negate;
    logic [SHIFT_W-1:0] shift;
  } sweep_cfg_t;

  function automatic logic [CDW-1:0] calc_delay(input logic [SHIFT_W-1:0] sh,
                                                input logic ph, input logic cold);
    logic [CDW-1:0] d;
    d = CDW'({sh, 1'b0}) + CDW'(5) - CDW'(ph);
    if (cold) d = d + CDW'(2);
    return d;
  endfunction
endpackage

// File: rtl/sq_sweep_pace.sv
`timescale 1ns/1ps
module sq_sweep_pace #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          frame_tick,
  input  logic [PW-1:0] pace,
  output logic          fire
);
  localparam logic [PW-1:0] TOP_V  = '1;
  localparam logic [PW-1:0] LAST_V = TOP_V - 1'b1;

  logic [PW-1:0] cnt_q, cnt_d, reload_v;

  assign reload_v = pace ^ TOP_V;

  always_comb begin
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (reload) begin
      cnt_d = reload_v;
    end else if (frame_tick) begin
      if (cnt_q >= LAST_V) begin
        cnt_d = reload_v;
        fire  = (pace != '0);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= TOP_V;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sq_sweep_delay.sv
`timescale 1ns/1ps
module sq_sweep_delay #(
  parameter int CW   = 5,
  parameter int HOLD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          load_unsh,
  input  logic          tick,
  input  logic          shift_nz,
  output logic          done,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          unsh_q, unsh_d, adv;

  assign adv = shift_nz || unsh_q || (cnt_q <= CW'(HOLD));
  assign cnt = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    unsh_d = unsh_q;
    done   = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d  = load_val;
      unsh_d = load_unsh;
    end else if (tick && (cnt_q != '0) && adv) begin
      cnt_d = cnt_q - 1'b1;
      done  = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      unsh_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      unsh_q <= unsh_d;
    end
  end
endmodule

// File: rtl/sq_sweep_unit.sv
`timescale 1ns/1ps
module sq_sweep_unit
  import sq_sweep_pkg::*;
#(
  parameter int PER_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [6:0]       cfg_wdata,
  input  logic             trig,
  input  logic [PER_W-1:0] trig_period,
  input  logic             frame_tick,
  input  logic             calc_tick,
  output logic [PER_W-1:0] period_out,
  output logic             period_load,
  output logic             ch_active
);
  sweep_cfg_t       cfg_q, cfg_d;
  logic [PER_W-1:0] shadow_q, shadow_d, addend_q, addend_d, dadd_q, dadd_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             load_q, load_d, act_q, act_d, wb_q, wb_d, ph_q, ph_d;
  logic [PER_W:0]   cand, kill_sum;
  logic             shift_nz, ovf, write_kill;
  logic             pace_fire, sched_frame, trig_sched;
  logic             dly_load, dly_clr, dly_unsh, calc_done;
  logic [CDW-1:0]   dly_val, dly_cnt;

  assign shift_nz    = (cfg_q.shift != '0);
  assign sched_frame = pace_fire && act_q && !trig;
  assign trig_sched  = trig && shift_nz;
  assign dly_load    = sched_frame || trig_sched;
  assign dly_clr     = trig && !shift_nz;
  assign dly_unsh    = !trig && !shift_nz;
  assign dly_val     = calc_delay(cfg_q.shift, ph_q, trig_sched && !act_q);

  sq_sweep_pace #(.PW(PACE_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .reload(trig), .frame_tick(frame_tick),
    .pace(cfg_q.pace), .fire(pace_fire)
  );

  sq_sweep_delay #(.CW(CDW), .HOLD(HOLD_LIM)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(dly_clr), .load(dly_load),
    .load_val(dly_val), .load_unsh(dly_unsh), .tick(calc_tick),
    .shift_nz(shift_nz), .done(calc_done), .cnt(dly_cnt)
  );

  // candidate period, one bit wider to expose the carry
  assign cand = cfg_q.negate ? ({1'b0, shadow_q} - {1'b0, addend_q})
                             : ({1'b0, shadow_q} + {1'b0, addend_q});
  assign ovf  = !cfg_q.negate && cand[PER_W];

  // write-time check on the last completed calculation
  assign kill_sum   = {1'b0, shadow_q} + {1'b0, dadd_q} + {{PER_W{1'b0}}, cfg_q.negate};
  assign write_kill = cfg_we && !cfg_wdata[3] && kill_sum[PER_W];

  always_comb begin
    cfg_d    = cfg_q;
    shadow_d = shadow_q;
    addend_d = addend_q;
    dadd_d   = dadd_q;
    per_d    = per_q;
    act_d    = act_q;
    wb_d     = wb_q;
    load_d   = 1'b0;
    ph_d     = ph_q ^ calc_tick;
    if (calc_done) begin
      dadd_d = cfg_q.negate ? ~addend_q : addend_q;
      if (ovf) begin
        act_d = 1'b0;
      end else if (wb_q && shift_nz && act_q) begin
        shadow_d = cand[PER_W-1:0];
        per_d    = cand[PER_W-1:0];
        load_d   = 1'b1;
      end
    end
    if (sched_frame) begin
      addend_d = shadow_q >> cfg_q.shift;
      wb_d     = 1'b1;
    end
    if (cfg_we) begin
      cfg_d = sweep_cfg_t'(cfg_wdata);
      if (write_kill) act_d = 1'b0;
    end
    if (trig) begin
      act_d    = 1'b1;
      shadow_d = trig_period;
      dadd_d   = '0;
      addend_d = trig_period >> cfg_q.shift;
      wb_d     = 1'b0;
      load_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      shadow_q <= '0;
      addend_q <= '0;
      dadd_q   <= '0;
      per_q    <= '0;
      load_q   <= 1'b0;
      act_q    <= 1'b0;
      wb_q     <= 1'b0;
      ph_q     <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      shadow_q <= shadow_d;
      addend_q <= addend_d;
      dadd_q   <= dadd_d;
      per_q    <= per_d;
      load_q   <= load_d;
      act_q    <= act_d;
      wb_q     <= wb_d;
      ph_q     <= ph_d;
    end
  end

  assign period_out  = per_q;
  assign period_load = load_q;
  assign ch_active   = act_q;
endmodule

// File: rtl/sq_sweep_chk.sv
`timescale 1ns/1ps
module sq_sweep_chk
  import sq_sweep_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           trig,
  input logic           cfg_we,
  input logic           calc_tick,
  input logic           calc_done,
  input logic           ch_active,
  input logic           period_load,
  input logic [CDW-1:0] dly_cnt
);
  assert_trig_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> ch_active);

  assert_rise_by_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_active) |-> $past(trig));

  assert_kill_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_active) |-> ($past(cfg_we) || $past(calc_done)));

  assert_load_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    period_load |-> ($past(calc_tick) && $past(ch_active)));

  assert_delay_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dly_cnt <= CDW'(MAX_DLY));
endmodule

bind sq_sweep_unit sq_sweep_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .calc_tick(calc_tick),
  .calc_done(calc_done), .ch_active(ch_active), .period_load(period_load),
  .dly_cnt(dly_cnt)
);

// File: tb/sq_sweep_unit_test.sv
`timescale 1ns/1ps
module sq_sweep_unit_test;
  localparam int CLK_P = 10;
  localparam int NVEC  = 14;
  // {shift, phase, delay, expected period} for a start period of 0x123
  localparam logic [19:0] VEC [NVEC] = '{
    {3'd1, 1'b0, 5'd7,  11'h1B4}, {3'd1, 1'b1, 5'd6,  11'h1B4},
    {3'd2, 1'b0, 5'd9,  11'h16B}, {3'd2, 1'b1, 5'd8,  11'h16B},
    {3'd3, 1'b0, 5'd11, 11'h147}, {3'd3, 1'b1, 5'd10, 11'h147},
    {3'd4, 1'b0, 5'd13, 11'h135}, {3'd4, 1'b1, 5'd12, 11'h135},
    {3'd5, 1'b0, 5'd15, 11'h12C}, {3'd5, 1'b1, 5'd14, 11'h12C},
    {3'd6, 1'b0, 5'd17, 11'h127}, {3'd6, 1'b1, 5'd16, 11'h127},
    {3'd7, 1'b0, 5'd19, 11'h125}, {3'd7, 1'b1, 5'd18, 11'h125}
  };

  logic        clk, rst_n, cfg_we, trig, frame_tick, calc_tick;
  logic [6:0]  cfg_wdata;
  logic [10:0] trig_period, period_out;
  logic        period_load, ch_active;
  int          n_chk, n_bad;

  sq_sweep_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .trig(trig), .trig_period(trig_period), .frame_tick(frame_tick),
    .calc_tick(calc_tick), .period_out(period_out), .period_load(period_load),
    .ch_active(ch_active)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [6:0] v);
    @(negedge clk);
    cfg_wdata = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_trig(input logic [10:0] p);
    @(negedge clk);
    trig_period = p; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic do_frame();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic tick_calc(output logic ld);
    @(negedge clk);
    calc_tick = 1'b1;
    @(negedge clk);
    calc_tick = 1'b0;
    ld = period_load;
  endtask

  task automatic run_calc(input int n, output logic any_ld);
    logic l;
    any_ld = 1'b0;
    for (int k = 0; k < n; k++) begin
      tick_calc(l);
      any_ld = any_ld | l;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic        ld, any;
    logic [19:0] v;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; trig = 1'b0;
    trig_period = '0; frame_tick = 1'b0; calc_tick = 1'b0;

    // R9 reset state
    do_reset();
    chk("R9 active", 32'(ch_active), 32'd0);
    chk("R9 load", 32'(period_load), 32'd0);
    chk("R9 period", 32'(period_out), 32'd0);

    // R3 R6 R1 delay table over every shift and both phases
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      do_reset();
      wr_cfg(7'h10);
      if (v[16]) tick_calc(ld);
      do_trig(11'h123);
      wr_cfg({3'd1, 1'b0, v[19:17]});
      do_frame();
      run_calc(int'(v[15:11]) - 1, any);
      chk("R3 no early load", 32'(any), 32'd0);
      tick_calc(ld);
      chk("R3 load on last tick", 32'(ld), 32'd1);
      chk("R6 new period", 32'(period_out), 32'(v[10:0]));
    end

    // R5 overflow on a frame calculation
    do_reset();
    wr_cfg(7'h10);
    do_trig(11'h700);
    wr_cfg(7'h11);
    do_frame();
    run_calc(6, any);
    chk("R5 alive before end", 32'(ch_active), 32'd1);
    tick_calc(ld);
    chk("R5 overflow kills", 32'(ch_active), 32'd0);
    chk("R5 no load on overflow", 32'(ld | any), 32'd0);

    // R8 trigger-time check: cold adds two counts, warm does not
    do_reset();
    wr_cfg(7'h01);
    do_trig(11'h100);
    chk("R8 trigger sets active", 32'(ch_active), 32'd1);
    run_calc(8, any);
    tick_calc(ld);
    chk("R8 check never loads", 32'(ld | any), 32'd0);
    chk("R8 period untouched", 32'(period_out), 32'd0);
    do_trig(11'h7F0);
    run_calc(5, any);
    chk("R8 warm check not early", 32'(ch_active), 32'd1);
    tick_calc(ld);
    chk("R8 warm check kills", 32'(ch_active), 32'd0);

    // R7 subtract then clear negate
    do_reset();
    wr_cfg(7'h19);
    do_trig(11'h400);
    run_calc(9, any);
    chk("R8 subtract check no load", 32'(any), 32'd0);
    do_frame();
    run_calc(5, any);
    tick_calc(ld);
    chk("R6 subtract load", 32'(ld), 32'd1);
    chk("R6 subtract period", 32'(period_out), 32'h200);
    wr_cfg(7'h1A);
    chk("R7 negate kept no kill", 32'(ch_active), 32'd1);
    wr_cfg(7'h12);
    chk("R7 negate cleared kills", 32'(ch_active), 32'd0);

    // R4 pause when shift zeroed mid-count
    do_reset();
    wr_cfg(7'h10);
    do_trig(11'h100);
    wr_cfg(7'h12);
    do_frame();
    wr_cfg(7'h10);
    run_calc(20, any);
    chk("R4 paused no load", 32'(any), 32'd0);
    wr_cfg(7'h12);
    run_calc(8, any);
    chk("R4 resumed not early", 32'(any), 32'd0);
    tick_calc(ld);
    chk("R4 resumed load", 32'(ld), 32'd1);
    chk("R4 resumed period", 32'(period_out), 32'h140);

    // R4 unshifted schedule keeps counting
    do_reset();
    wr_cfg(7'h10);
    do_trig(11'h500);
    do_frame();
    run_calc(4, any);
    chk("R4 unshifted alive", 32'(ch_active), 32'd1);
    tick_calc(ld);
    chk("R4 unshifted overflow", 32'(ch_active), 32'd0);

    // R2 pace of two, then pace zero
    do_reset();
    wr_cfg(7'h20);
    do_trig(11'h100);
    wr_cfg(7'h21);
    do_frame();
    run_calc(12, any);
    chk("R2 first frame no calc", 32'(any), 32'd0);
    do_frame();
    run_calc(6, any);
    tick_calc(ld);
    chk("R2 second frame calc", 32'(ld & !any), 32'd1);
    chk("R2 period", 32'(period_out), 32'h180);
    wr_cfg(7'h01);
    do_frame(); do_frame(); do_frame();
    run_calc(25, any);
    chk("R2 pace zero idle", 32'(any), 32'd0);
    chk("R1 active kept", 32'(ch_active), 32'd1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule